// File: doc/BRIEF.md
# Single-Locality Access and Interrupt Register Unit

This unit is the device-side register slice of a trusted-module style memory-mapped interface. It serves one host locality. The host asks for the locality through the access register and gives it back through the same register. The unit records whether the locality is currently held and shows that state back to the host.

It also latches event pulses from the command engine into a status word: command ready, status valid and data available. It adds its own locality-change event, which is raised whenever the locality is granted. A write-one-to-clear scheme empties the status word, but only while the locality is held. Per-event enables, a global enable and an interrupt vector number combine to drive a single level-sensitive interrupt line.

Accesses are 32-bit words at word-aligned offsets, with four byte-lane enables. Reads have no side effects and return data combinationally from the registered state. Writes take effect at the next rising clock edge.

Top module: `loc_irq_unit`

## Requirements
- R1: After reset the locality is not held and `loc_active` is 0. At offset 0x0 a read returns 0x80. Reads at 0x8, 0xC and 0x10 return 0, and `irq` is 0.
- R2: A write at offset 0x0 with lane 0 enabled and bit 1 set, while the locality is free, grants it. From the next cycle a read at 0x0 returns 0xA0: bit 7 is always 1 and bit 5 means held. `loc_active` is also 1 from that cycle.
- R3: A write at offset 0x0 with lane 0 enabled and bit 5 set, while the locality is held, releases it. From the next cycle a read at 0x0 returns 0x80.
- R4: A request made while the locality is already held has no effect. The locality stays held and no locality-change event is raised.
- R5: A grant sets status bit 2 (locality change) in the same cycle that the locality becomes held.
- R6: A one-cycle pulse on `ev_data_avail`, `ev_sts_valid` or `ev_cmd_ready` sets status bit 0, 1 or 7 respectively at the next edge. This happens whether or not the locality is held. The bit stays set until it is cleared.
- R7: Writing 1 to a status bit at offset 0x10 clears that bit, but only while the locality is held. Writes to 0x10 while the locality is free leave the status unchanged.
- R8: The enable register at offset 0x8 stores bits 31 (global), 7, 2, 1 and 0, and reads them back. All other bits read 0. It can be written whether or not the locality is held.
- R9: The vector register at offset 0xC stores an 8-bit value in bits 7:0. `irq` can be 1 only when the vector lies in the range 1 to 15.
- R10: `irq` equals: global enable AND legal vector AND (any status bit whose own enable bit is set).
- R11: Byte lanes whose enable is 0 are not written. Unmapped word offsets read 0.
- R12: If an event pulse and a write-one-to-clear of the same status bit occur in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | ADDR_W | Byte offset of the accessed word |
| wdata | input | 32 | Write data |
| be | input | 4 | Byte-lane enables for writes |
| rdata | output | 32 | Read data for `addr` (combinational) |
| ev_cmd_ready | input | 1 | Command-ready event pulse |
| ev_sts_valid | input | 1 | Status-valid event pulse |
| ev_data_avail | input | 1 | Data-available event pulse |
| irq | output | 1 | Level interrupt request |
| loc_active | output | 1 | Locality currently held |

## Verification
The bench sweeps every enable combination against every combination of engine-event status bits, and sweeps all 256 vector values. It therefore catches an interrupt that ignores an individual enable or the global enable. It also catches an interrupt that fires on vector 0 or on a vector above 15.

The bench tries to clear status while the locality is free; a design that clears anyway would lose pending events. It repeats a request while the locality is held; a design that re-grants would raise a spurious locality-change event. It pulses an event in the same cycle as a clear; a design that lets the clear win would drop that event. Finally, it writes the enable register with lane 3 disabled, to expose a global enable that is set through a masked lane.

// File: rtl/loc_irq_pkg.sv
package loc_irq_pkg;
    localparam int DATA_W = 32;

    // word offsets
    localparam int OFF_ACCESS  = 'h0;
    localparam int OFF_INT_EN  = 'h8;
    localparam int OFF_INT_VEC = 'hC;
    localparam int OFF_INT_STS = 'h10;

    // access register fields
    localparam int ACC_REQ_BIT    = 1;
    localparam int ACC_HELD_BIT   = 5;
    localparam int ACC_GIVE_BIT   = 5;
    localparam int ACC_VALID_BIT  = 7;

    // interrupt bits shared by enable and status
    localparam int EVB_DATA_AV  = 0;
    localparam int EVB_STS_OK   = 1;
    localparam int EVB_LOC_CHG  = 2;
    localparam int EVB_CMD_RDY  = 7;
    localparam int EVB_GLOBAL   = 31;

    localparam logic [DATA_W-1:0] STS_MASK =
        (DATA_W'(1) << EVB_DATA_AV) | (DATA_W'(1) << EVB_STS_OK) |
        (DATA_W'(1) << EVB_LOC_CHG) | (DATA_W'(1) << EVB_CMD_RDY);
    localparam logic [DATA_W-1:0] EN_MASK = STS_MASK | (DATA_W'(1) << EVB_GLOBAL);

    typedef struct packed {
        logic acc;
        logic en;
        logic vec;
        logic sts;
    } reg_sel_t;
endpackage

// File: rtl/lir_decode.sv
module lir_decode
    import loc_irq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    always_comb begin
        sel     = '0;
        sel.acc = (addr == ADDR_W'(OFF_ACCESS));
        sel.en  = (addr == ADDR_W'(OFF_INT_EN));
        sel.vec = (addr == ADDR_W'(OFF_INT_VEC));
        sel.sts = (addr == ADDR_W'(OFF_INT_STS));
    end
endmodule

// File: rtl/lir_locality.sv
module lir_locality (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_wr,
    input  logic req_bit,
    input  logic give_bit,
    output logic held,
    output logic grant
);
    typedef struct packed {
        logic held;
    } loc_state_t;

    loc_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        grant = 1'b0;
        if (acc_wr) begin
            if (st_q.held) begin
                if (give_bit) st_d.held = 1'b0;
            end else if (req_bit) begin
                st_d.held = 1'b1;
                grant     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held = st_q.held;
endmodule

// File: rtl/lir_irq.sv
module lir_irq
    import loc_irq_pkg::*;
#(
    parameter int VEC_W   = 8,
    parameter int VEC_MAX = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_t          sel,
    input  logic [3:0]        be,
    input  logic [DATA_W-1:0] wdata,
    input  logic              held,
    input  logic              grant,
    input  logic              ev_cmd_ready,
    input  logic              ev_sts_valid,
    input  logic              ev_data_avail,
    output logic [DATA_W-1:0] en_q,
    output logic [VEC_W-1:0]  vec_q,
    output logic [DATA_W-1:0] sts_q,
    output logic              irq
);
    typedef struct packed {
        logic [DATA_W-1:0] en;
        logic [VEC_W-1:0]  vec;
        logic [DATA_W-1:0] sts;
    } irq_state_t;

    irq_state_t st_d, st_q;
    logic [DATA_W-1:0] lane_m;
    logic [DATA_W-1:0] set_v;
    logic [DATA_W-1:0] clr_v;
    logic              vec_ok;

    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign lane_m[g*8 +: 8] = {8{be[g]}};
    end

    always_comb begin
        set_v = '0;
        set_v[EVB_DATA_AV] = ev_data_avail;
        set_v[EVB_STS_OK]  = ev_sts_valid;
        set_v[EVB_LOC_CHG] = grant;
        set_v[EVB_CMD_RDY] = ev_cmd_ready;

        clr_v = '0;
        if (wr_en && sel.sts && held) clr_v = wdata & lane_m & STS_MASK;

        st_d = st_q;
        if (wr_en && sel.en)
            st_d.en = (st_q.en & ~lane_m) | (wdata & lane_m & EN_MASK);
        if (wr_en && sel.vec && be[0])
            st_d.vec = wdata[VEC_W-1:0];
        st_d.sts = (st_q.sts & ~clr_v) | set_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vec_ok = (st_q.vec != '0) && (int'(st_q.vec) <= VEC_MAX);
    assign irq    = st_q.en[EVB_GLOBAL] && vec_ok && (|(st_q.sts & st_q.en & STS_MASK));
    assign en_q   = st_q.en;
    assign vec_q  = st_q.vec;
    assign sts_q  = st_q.sts;
endmodule

// File: rtl/loc_irq_unit.sv
module loc_irq_unit
    import loc_irq_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int VEC_W   = 8,
    parameter int VEC_MAX = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [3:0]        be,
    output logic [31:0]       rdata,
    input  logic              ev_cmd_ready,
    input  logic              ev_sts_valid,
    input  logic              ev_data_avail,
    output logic              irq,
    output logic              loc_active
);
    reg_sel_t          sel;
    logic              grant;
    logic [DATA_W-1:0] en_q;
    logic [VEC_W-1:0]  vec_q;
    logic [DATA_W-1:0] sts_q;

    lir_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    lir_locality u_loc (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_wr   (wr_en && sel.acc && be[0]),
        .req_bit  (wdata[ACC_REQ_BIT]),
        .give_bit (wdata[ACC_GIVE_BIT]),
        .held     (loc_active),
        .grant    (grant)
    );

    lir_irq #(.VEC_W(VEC_W), .VEC_MAX(VEC_MAX)) u_irq (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .sel           (sel),
        .be            (be),
        .wdata         (wdata),
        .held          (loc_active),
        .grant         (grant),
        .ev_cmd_ready  (ev_cmd_ready),
        .ev_sts_valid  (ev_sts_valid),
        .ev_data_avail (ev_data_avail),
        .en_q          (en_q),
        .vec_q         (vec_q),
        .sts_q         (sts_q),
        .irq           (irq)
    );

    always_comb begin
        rdata = '0;
        if (sel.acc) begin
            rdata[ACC_VALID_BIT] = 1'b1;
            rdata[ACC_HELD_BIT]  = loc_active;
        end else if (sel.en) begin
            rdata = en_q;
        end else if (sel.vec) begin
            rdata = 32'(vec_q);
        end else if (sel.sts) begin
            rdata = sts_q;
        end
    end
endmodule

// File: rtl/lir_checker.sv
module lir_checker #(
    parameter int ADDR_W  = 12,
    parameter int VEC_W   = 8,
    parameter int VEC_MAX = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [1:0]        acc_bits,
    input logic              be0,
    input logic              ev_cmd_ready,
    input logic              ev_data_avail,
    input logic              loc_active,
    input logic              irq,
    input logic [31:0]       en_q,
    input logic [VEC_W-1:0]  vec_q,
    input logic [31:0]       sts_q
);
    logic acc_wr;
    assign acc_wr = wr_en && (addr == '0) && be0;

    // acc_bits[0] = request, acc_bits[1] = give up
    assert_grant_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_bits[0] && !loc_active) |=> loc_active);

    assert_release_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_bits[1] && loc_active) |=> !loc_active);

    assert_grant_flags_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loc_active) |-> sts_q[2]);

    assert_event_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_cmd_ready && ev_data_avail) |=> (sts_q[7] && sts_q[0]));

    assert_no_clear_when_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !loc_active |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

    assert_bad_vector_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((vec_q == '0) || (int'(vec_q) > VEC_MAX)) |-> !irq);

    assert_irq_needs_global_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> en_q[31]);
endmodule

bind loc_irq_unit lir_checker #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .VEC_MAX(VEC_MAX)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .addr          (addr),
    .acc_bits      ({wdata[5], wdata[1]}),
    .be0           (be[0]),
    .ev_cmd_ready  (ev_cmd_ready),
    .ev_data_avail (ev_data_avail),
    .loc_active    (loc_active),
    .irq           (irq),
    .en_q          (en_q),
    .vec_q         (vec_q),
    .sts_q         (sts_q)
);

// File: tb/tb_loc_irq_unit.sv
`timescale 1ns/1ps
module tb_loc_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  be = '0;
    logic [31:0] rdata;
    logic        ev_cmd_ready = 1'b0;
    logic        ev_sts_valid = 1'b0;
    logic        ev_data_avail = 1'b0;
    logic        irq;
    logic        loc_active;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    loc_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .be(be), .rdata(rdata), .ev_cmd_ready(ev_cmd_ready),
        .ev_sts_valid(ev_sts_valid), .ev_data_avail(ev_data_avail),
        .irq(irq), .loc_active(loc_active)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] b);
        @(negedge clk);
        addr = a; wdata = d; be = b; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; be = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    // m: bit0 data avail, bit1 status valid, bit2 command ready
    task automatic pulse(input logic [2:0] m);
        @(negedge clk);
        ev_data_avail = m[0]; ev_sts_valid = m[1]; ev_cmd_ready = m[2];
        @(negedge clk);
        ev_data_avail = 1'b0; ev_sts_valid = 1'b0; ev_cmd_ready = 1'b0;
    endtask

    function automatic logic [31:0] en_word(input logic [4:0] m);
        en_word = {m[4], 23'b0, m[3], 4'b0, m[2], m[1], m[0]};
    endfunction

    function automatic logic [31:0] ev_word(input logic [2:0] s);
        ev_word = {24'b0, s[2], 5'b0, s[1], s[0]};
    endfunction

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(12'h0, d);  chk("R1 access", d, 32'h80);
        rd(12'h8, d);  chk("R1 enable", d, 0);
        rd(12'hC, d);  chk("R1 vector", d, 0);
        rd(12'h10, d); chk("R1 status", d, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 loc_active", {31'b0, loc_active}, 0);

        // R7 clear ignored while free
        pulse(3'b001);
        wr(12'h10, 32'hFFFF_FFFF, 4'hF);
        rd(12'h10, d); chk("R7 clear while free", d, 32'h1);

        // R2/R5 grant
        wr(12'h0, 32'h02, 4'h1);
        rd(12'h0, d);  chk("R2 access after grant", d, 32'hA0);
        chk("R2 loc_active", {31'b0, loc_active}, 1);
        rd(12'h10, d); chk("R5 loc change set", d, 32'h5);

        // R7 clear works while held
        wr(12'h10, 32'h5, 4'h1);
        rd(12'h10, d); chk("R7 clear while held", d, 0);

        // R4 repeated request
        wr(12'h0, 32'h02, 4'h1);
        rd(12'h0, d);  chk("R4 still held", d, 32'hA0);
        rd(12'h10, d); chk("R4 no new change", d, 0);

        // R12 set beats clear
        @(negedge clk);
        addr = 12'h10; wdata = 32'h80; be = 4'h1; wr_en = 1'b1; ev_cmd_ready = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; be = '0; ev_cmd_ready = 1'b0;
        rd(12'h10, d); chk("R12 set wins", d, 32'h80);
        wr(12'h10, 32'h80, 4'h1);

        // R8/R11 enable storage and lanes
        wr(12'h8, 32'hFFFF_FFFF, 4'h7);
        rd(12'h8, d);  chk("R11 masked lane 3", d, 32'h87);
        wr(12'h8, 32'hFFFF_FFFF, 4'hF);
        rd(12'h8, d);  chk("R8 enable readback", d, 32'h8000_0087);
        rd(12'h4, d);  chk("R11 unmapped", d, 0);
        rd(12'h20, d); chk("R11 unmapped high", d, 0);

        // R9 vector sweep with a pending enabled event
        pulse(3'b010);
        for (int v = 0; v < 256; v++) begin
            wr(12'hC, 32'(v), 4'h1);
            rd(12'hC, d);
            chk("R9 vector readback", d, 32'(v));
            chk("R9 irq vs vector", {31'b0, irq}, {31'b0, (v >= 1 && v <= 15)});
        end
        wr(12'hC, 32'h5, 4'hE);
        rd(12'hC, d); chk("R11 vector lane0 off", d, 32'hFF);
        wr(12'hC, 32'h5, 4'h1);

        // R6/R10 sweep events x enables
        for (int s = 0; s < 8; s++) begin
            for (int m = 0; m < 32; m++) begin
                logic [31:0] ew;
                logic        exp_irq;
                wr(12'h10, 32'h87, 4'h1);
                wr(12'h8, en_word(5'(m)), 4'hF);
                pulse(3'(s));
                ew = ev_word(3'(s));
                rd(12'h10, d); chk("R6 status latch", d, ew);
                exp_irq = m[4] && ((s[0] && m[0]) || (s[1] && m[1]) || (s[2] && m[3]));
                chk("R10 irq combine", {31'b0, irq}, {31'b0, exp_irq});
            end
        end

        // R10 locality change source
        wr(12'h0, 32'h20, 4'h1);
        wr(12'h8, en_word(5'b10100), 4'hF);
        chk("R10 no change pending", {31'b0, irq}, 0);
        wr(12'h0, 32'h02, 4'h1);
        chk("R10 irq from change", {31'b0, irq}, 1);

        // R3 release
        wr(12'h0, 32'h20, 4'h1);
        rd(12'h0, d); chk("R3 released", d, 32'h80);
        chk("R3 loc_active", {31'b0, loc_active}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule